// File: doc/BRIEF.md
# Monochrome Glyph Expansion Unit

This unit turns one-bit-per-pixel glyph rows into 32-bit colour pixel writes for a frame buffer. The host first loads a row width (1 to 32 pixels), a packed start position, a packed per-row step, two colours, a mode word and a plane mask. It then pushes one 32-bit bitmap word per glyph row. The unit reads each word from bit 31 downwards and emits one pixel per clock, moving rightwards from the current position. A set bit selects the foreground colour. A clear bit selects the background colour, or, in transparent mode, takes its cycle without a write.

The host sees a single register write port and one `ready` output. While a row is being emitted, `ready` is low and every host write is dropped, so the host waits for `ready` before its next write. When a row ends, the position moves by the step register, so consecutive data writes draw the rows of a glyph. The pixel port carries the coordinates, the colour, a write enable, and the plane mask and raster-operation code that the frame-buffer side applies.

Top module: `glyph_expander`

## Requirements
- R1: After reset `ready` is 1, `px_we` is 0, the position is (0,0), the width is 32, the step is X=0/Y=1, the plane mask is all ones, the raster code is 0 and the mode is opaque. While idle, `px_x`/`px_y` show the current row position.
- R2: A write takes effect at a clock edge where `cfg_we` and `ready` are both 1. `cfg_sel` chooses the register: 0 position (Y in bits 31:16, X in bits 15:0), 1 width (bits 5:0), 2 step (Y step in 31:16, X step in 15:0), 3 foreground (31:0), 4 background (31:0), 5 colour pair, 6 mode (bit 0 transparent, bits 5:4 raster code), 7 plane mask (31:0), 8 row data (31:0).
- R3: A width value of 0 is taken as 1, and any value above 32 is taken as 32.
- R4: A data write accepted at edge k produces pixel i (for i from 0 to width-1) in the cycle after edge k+i, at x = X+i and y = Y, using bit 31-i. `ready` stays 0 for exactly width cycles.
- R5: In opaque mode every pixel of the row has `px_we`=1, with the foreground colour for a set bit and the background colour for a clear bit.
- R6: In transparent mode a clear bit gives `px_we`=0 but still uses its cycle, and a set bit writes the foreground colour.
- R7: Bits of the row word below bit 32-width have no effect on any output.
- R8: When a row ends, X and Y each advance by their step field, modulo 2^16.
- R9: A position write sets the position that the next data write uses.
- R10: Writes presented while `ready` is 0 are discarded and change no register.
- R11: Every pixel carries the current plane mask on `px_pmask` and the raster code on `px_rop`.
- R12: A colour-pair write loads the foreground from bits 63:32 and the background from bits 31:0 in a single write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 64 | Host write data |
| ready | output | 1 | High when the unit accepts host writes |
| px_we | output | 1 | Pixel write enable |
| px_x | output | 16 | Pixel X coordinate (row position while idle) |
| px_y | output | 16 | Pixel Y coordinate (row position while idle) |
| px_color | output | 32 | Pixel colour |
| px_pmask | output | 32 | Plane mask for the pixel write |
| px_rop | output | 2 | Raster operation code for the pixel write |

## Verification
The hardest case to reach from the ports is a register write that arrives while a row is being emitted. The host drives writes only through the same port that `ready` guards, so the stimulus has to force the collision deliberately. The bench raises a position write in the first cycle of selected rows, including one-pixel rows where that cycle is also the last. It then checks that the idle position afterwards equals the old position plus the step. Random rows also mix transparent rows, width values outside 1 to 32, and positions close to the 16-bit wrap, so that the row-end step crosses the coordinate boundary.

// File: rtl/glyph_exp_pkg.sv
// Package: shared select codes and raster codes for the glyph expansion unit.
// Assumes a 4-bit register select on the host port.
package glyph_exp_pkg;
    localparam int SEL_W = 4;
    localparam int ROP_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_POS   = 4'd0,
        SEL_WIDTH = 4'd1,
        SEL_STEP  = 4'd2,
        SEL_FG    = 4'd3,
        SEL_BG    = 4'd4,
        SEL_PAIR  = 4'd5,
        SEL_MODE  = 4'd6,
        SEL_PMASK = 4'd7,
        SEL_DATA  = 4'd8
    } glyph_sel_e;

    typedef enum logic [ROP_W-1:0] {
        ROP_SRC = 2'd0,
        ROP_DST = 2'd1,
        ROP_XOR = 2'd2,
        ROP_RSV = 2'd3
    } glyph_rop_e;
endpackage

// File: rtl/glyph_regs.sv
// glyph_regs: host-visible configuration registers and the row position.
// The caller gates wr_en with ready, so wr_en and row_done never occur
// in the same cycle. The width is clamped to 1..ROW_W when it is written.
module glyph_regs
    import glyph_exp_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 32,
    parameter int ROW_W   = 32,
    parameter int WID_W   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic [2*COLOR_W-1:0] wdata,
    input  logic                 row_done,
    output logic [COORD_W-1:0]   pos_x,
    output logic [COORD_W-1:0]   pos_y,
    output logic [COORD_W-1:0]   step_x,
    output logic [COORD_W-1:0]   step_y,
    output logic [WID_W-1:0]     width,
    output logic [COLOR_W-1:0]   fg,
    output logic [COLOR_W-1:0]   bg,
    output logic                 transp,
    output logic [ROP_W-1:0]     rop,
    output logic [COLOR_W-1:0]   pmask
);
    localparam logic [WID_W-1:0]   W_MAX  = WID_W'(ROW_W);
    localparam logic [WID_W-1:0]   W_ONE  = WID_W'(1);
    localparam logic [COORD_W-1:0] STEP_Y_RST = COORD_W'(1);

    // Map a raw width value onto the legal range 1..ROW_W.
    function automatic logic [WID_W-1:0] clamp_w(input logic [WID_W-1:0] v);
        if (v == '0)
            return W_ONE;
        else if (v > W_MAX)
            return W_MAX;
        else
            return v;
    endfunction

    glyph_sel_e sel_e;
    assign sel_e = glyph_sel_e'(sel);

    // Register updates: step after a row, otherwise apply a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x  <= '0;
            pos_y  <= '0;
            step_x <= '0;
            step_y <= STEP_Y_RST;
            width  <= W_MAX;
            fg     <= '0;
            bg     <= '0;
            transp <= 1'b0;
            rop    <= ROP_SRC;
            pmask  <= '1;
        end else if (row_done) begin
            pos_x <= pos_x + step_x;
            pos_y <= pos_y + step_y;
        end else if (wr_en) begin
            unique case (sel_e)
                SEL_POS: begin
                    pos_y <= wdata[2*COORD_W-1:COORD_W];
                    pos_x <= wdata[COORD_W-1:0];
                end
                SEL_WIDTH: width <= clamp_w(wdata[WID_W-1:0]);
                SEL_STEP: begin
                    step_y <= wdata[2*COORD_W-1:COORD_W];
                    step_x <= wdata[COORD_W-1:0];
                end
                SEL_FG:    fg <= wdata[COLOR_W-1:0];
                SEL_BG:    bg <= wdata[COLOR_W-1:0];
                SEL_PAIR: begin
                    fg <= wdata[2*COLOR_W-1:COLOR_W];
                    bg <= wdata[COLOR_W-1:0];
                end
                SEL_MODE: begin
                    transp <= wdata[0];
                    rop    <= wdata[5:4];
                end
                SEL_PMASK: pmask <= wdata[COLOR_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/glyph_row_seq.sv
// glyph_row_seq: walks one bitmap row, MSB first, one pixel per cycle.
// Assumes width is held stable while busy (the host port is blocked then).
module glyph_row_seq #(
    parameter int ROW_W = 32,
    parameter int WID_W = 6,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WID_W-1:0] width,
    input  logic [ROW_W-1:0] word_in,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             bit_cur,
    output logic             row_done
);
    logic [ROW_W-1:0] word_q;
    logic             last;

    // Last pixel of the row when the index reaches width-1.
    assign last     = (WID_W'(idx) == width - WID_W'(1));
    assign row_done = busy & last;
    assign bit_cur  = word_q[ROW_W-1];

    // Row state: load on start, shift and count while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            word_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            idx    <= '0;
            word_q <= word_in;
        end else if (busy) begin
            word_q <= word_q << 1;
            if (last) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/glyph_pix_gen.sv
// glyph_pix_gen: forms the pixel write from the current bit and the colours.
// Purely combinational. While idle it shows the row position and no write.
module glyph_pix_gen #(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 32,
    parameter int IDX_W   = 5
) (
    input  logic               busy,
    input  logic               bit_cur,
    input  logic [IDX_W-1:0]   idx,
    input  logic [COORD_W-1:0] pos_x,
    input  logic [COORD_W-1:0] pos_y,
    input  logic [COLOR_W-1:0] fg,
    input  logic [COLOR_W-1:0] bg,
    input  logic               transp,
    output logic               we,
    output logic [COORD_W-1:0] x,
    output logic [COORD_W-1:0] y,
    output logic [COLOR_W-1:0] color
);
    // Pixel selection: colour from the bit, write suppressed on clear bits if transparent.
    always_comb begin
        x     = busy ? pos_x + COORD_W'(idx) : pos_x;
        y     = pos_y;
        color = bit_cur ? fg : bg;
        we    = busy & (bit_cur | ~transp);
    end
endmodule

// File: rtl/glyph_expander.sv
// glyph_expander: top of the monochrome glyph expansion unit.
// Host writes are accepted only while ready is high. A data write starts
// a row of width pixels, and ready stays low until the row is done.
module glyph_expander
    import glyph_exp_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 32,
    parameter int ROW_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [3:0]           cfg_sel,
    input  logic [2*COLOR_W-1:0] cfg_wdata,
    output logic                 ready,
    output logic                 px_we,
    output logic [COORD_W-1:0]   px_x,
    output logic [COORD_W-1:0]   px_y,
    output logic [COLOR_W-1:0]   px_color,
    output logic [COLOR_W-1:0]   px_pmask,
    output logic [1:0]           px_rop
);
    localparam int WID_W = $clog2(ROW_W + 1);
    localparam int IDX_W = (ROW_W > 1) ? $clog2(ROW_W) : 1;

    logic               busy, bit_cur, row_done, accept, start, reg_we;
    logic [IDX_W-1:0]   idx;
    logic [COORD_W-1:0] pos_x, pos_y, step_x, step_y;
    logic [WID_W-1:0]   width;
    logic [COLOR_W-1:0] fg_q, bg_q, pmask_q;
    logic               transp_q;
    logic [ROP_W-1:0]   rop_q;

    // Host port gating: all writes are dropped while a row is in flight.
    assign ready  = ~busy;
    assign accept = cfg_we & ready;
    assign start  = accept & (glyph_sel_e'(cfg_sel) == SEL_DATA);
    assign reg_we = accept & ~start;

    glyph_regs #(
        .COORD_W(COORD_W), .COLOR_W(COLOR_W), .ROW_W(ROW_W), .WID_W(WID_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .row_done(row_done),
        .pos_x(pos_x), .pos_y(pos_y), .step_x(step_x), .step_y(step_y),
        .width(width), .fg(fg_q), .bg(bg_q), .transp(transp_q),
        .rop(rop_q), .pmask(pmask_q)
    );

    glyph_row_seq #(
        .ROW_W(ROW_W), .WID_W(WID_W), .IDX_W(IDX_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .width(width),
        .word_in(cfg_wdata[ROW_W-1:0]), .busy(busy), .idx(idx),
        .bit_cur(bit_cur), .row_done(row_done)
    );

    glyph_pix_gen #(
        .COORD_W(COORD_W), .COLOR_W(COLOR_W), .IDX_W(IDX_W)
    ) pix_i (
        .busy(busy), .bit_cur(bit_cur), .idx(idx), .pos_x(pos_x),
        .pos_y(pos_y), .fg(fg_q), .bg(bg_q), .transp(transp_q),
        .we(px_we), .x(px_x), .y(px_y), .color(px_color)
    );

    // Fill-engine attributes ride along with every pixel write.
    assign px_pmask = pmask_q;
    assign px_rop   = rop_q;
endmodule

// File: rtl/glyph_expander_chk.sv
// glyph_expander_chk: temporal checks on the glyph expansion unit, bound to the top.
module glyph_expander_chk #(
    parameter int COORD_W = 16,
    parameter int COLOR_W = 32,
    parameter int ROW_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ready,
    input logic               px_we,
    input logic [COORD_W-1:0] px_x,
    input logic [COORD_W-1:0] px_y,
    input logic [COLOR_W-1:0] px_color,
    input logic [COLOR_W-1:0] fg_q,
    input logic [COLOR_W-1:0] bg_q,
    input logic               transp_q,
    input logic [COORD_W-1:0] step_y
);
    localparam logic [COORD_W-1:0] ONE_C = COORD_W'(1);
    logic [7:0] run_cnt;

    // Length of the current not-ready run, used to bound the row length.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= '0;
        else if (!ready) run_cnt <= run_cnt + 8'd1;
        else             run_cnt <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> (ready && !px_we)); // R1
    AST_WE_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) px_we |-> !ready); // R4
    AST_ROW_LEN: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> (run_cnt < 8'(ROW_W))); // R3
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!ready && !$past(ready)) |-> (px_x == $past(px_x) + ONE_C && px_y == $past(px_y))); // R4
    AST_COLOR_SRC: assert property (@(posedge clk) disable iff (!rst_n) px_we |-> (px_color == fg_q || px_color == bg_q)); // R5
    AST_TRANSP_FG: assert property (@(posedge clk) disable iff (!rst_n) (px_we && transp_q) |-> px_color == fg_q); // R6
    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> px_y == $past(px_y) + $past(step_y)); // R8
endmodule

bind glyph_expander glyph_expander_chk #(
    .COORD_W(COORD_W), .COLOR_W(COLOR_W), .ROW_W(ROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ready(ready), .px_we(px_we), .px_x(px_x),
    .px_y(px_y), .px_color(px_color), .fg_q(fg_q), .bg_q(bg_q),
    .transp_q(transp_q), .step_y(step_y)
);

// File: tb/glyph_expander_tb_top.sv
module glyph_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        ready, px_we;
    logic [15:0] px_x, px_y;
    logic [31:0] px_color, px_pmask;
    logic [1:0]  px_rop;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Bench-side model of the programmed state.
    logic [15:0] m_x, m_y, m_sx, m_sy;
    logic [5:0]  m_w;
    logic [31:0] m_fg, m_bg, m_pm;
    logic        m_tr;
    logic [1:0]  m_rop;

    always #2 clk = ~clk;

    glyph_expander dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ready(ready), .px_we(px_we), .px_x(px_x),
        .px_y(px_y), .px_color(px_color), .px_pmask(px_pmask), .px_rop(px_rop)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] clampw(input logic [5:0] v);
        if (v == 0) return 6'd1;
        if (v > 6'd32) return 6'd32;
        return v;
    endfunction

    // Host register write with model update (R2, R3, R12).
    task automatic hwr(input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (s)
            4'd0: begin m_y = d[31:16]; m_x = d[15:0]; end
            4'd1: m_w = clampw(d[5:0]);
            4'd2: begin m_sy = d[31:16]; m_sx = d[15:0]; end
            4'd3: m_fg = d[31:0];
            4'd4: m_bg = d[31:0];
            4'd5: begin m_fg = d[63:32]; m_bg = d[31:0]; end
            4'd6: begin m_tr = d[0]; m_rop = d[5:4]; end
            4'd7: m_pm = d[31:0];
            default: ;
        endcase
    endtask

    // One row: push the word, check every pixel cycle, then the idle position.
    task automatic row(input logic [31:0] word, input bit intrude);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd8; cfg_wdata = {32'hDEAD_BEEF, word};
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 0; i < int'(m_w); i++) begin
            logic b, ewe;
            logic [15:0] ex;
            if (i > 0) @(negedge clk);
            b   = word[31-i];
            ewe = b | ~m_tr;
            ex  = m_x + 16'(i);
            chk(ready == 1'b0, "R4", "ready low in row", 64'(ready), 64'd0);
            chk(px_we == ewe, m_tr ? "R6" : "R5", "px_we", 64'(px_we), 64'(ewe));
            if (ewe) begin
                chk(px_x == ex && px_y == m_y, "R4", "pixel xy",
                    {32'd0, px_y, px_x}, {32'd0, m_y, ex});
                chk(px_color == (b ? m_fg : m_bg), m_tr ? "R6" : "R5", "colour",
                    64'(px_color), 64'(b ? m_fg : m_bg));
                chk(px_pmask == m_pm && px_rop == m_rop, "R11", "mask/rop",
                    {30'd0, px_rop, px_pmask}, {30'd0, m_rop, m_pm});
            end
            if (intrude && i == 0) begin
                cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 64'h0000_0000_1234_5678;
            end else begin
                cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        cfg_we = 1'b0;
        m_x = m_x + m_sx;
        m_y = m_y + m_sy;
        chk(ready == 1'b1, "R4", "ready after row", 64'(ready), 64'd1);
        chk(px_x == m_x && px_y == m_y, intrude ? "R10" : "R8", "idle position",
            {32'd0, px_y, px_x}, {32'd0, m_y, m_x});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_x = 0; m_y = 0; m_sx = 0; m_sy = 16'd1; m_w = 6'd32;
        m_fg = 0; m_bg = 0; m_pm = 32'hFFFF_FFFF; m_tr = 0; m_rop = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1 && px_we == 1'b0, "R1", "ready/we", {62'd0, ready, px_we}, 64'd2);
        chk(px_x == 0 && px_y == 0, "R1", "position", {32'd0, px_y, px_x}, 64'd0);
        chk(px_pmask == 32'hFFFF_FFFF && px_rop == 2'd0, "R1", "mask/rop",
            {30'd0, px_rop, px_pmask}, 64'h0_FFFF_FFFF);

        // R5/R8: opaque default width and default step, two rows
        hwr(4'd0, 64'h0000_000A_0005);
        hwr(4'd3, 64'h0000_0000_00FF_0000);
        hwr(4'd4, 64'h0000_0000_0000_00FF);
        row(32'hA5F0_0F5A, 1'b0);
        row(32'h0123_4567, 1'b0);

        // R6/R7: transparent, width 8, low bits set but ignored
        hwr(4'd6, 64'h1);
        hwr(4'd1, 64'd8);
        row(32'h81FF_FFFF, 1'b0);
        row(32'h7E00_0000, 1'b0);

        // R12: colour pair in one write; R11: mask and raster code
        hwr(4'd5, 64'h1111_2222_3333_4444);
        hwr(4'd6, 64'h20);
        hwr(4'd7, 64'h0000_0000_00FF_00FF);
        row(32'hC3C3_C3C3, 1'b0);

        // R3: width 0 -> 1, width 45 -> 32
        hwr(4'd1, 64'd0);
        row(32'h8000_0000, 1'b0);
        hwr(4'd1, 64'd45);
        row(32'hFFFF_0000, 1'b0);

        // R10: position write during a row is dropped (normal and 1-pixel rows)
        hwr(4'd1, 64'd5);
        row(32'hF800_0000, 1'b1);
        hwr(4'd1, 64'd1);
        row(32'h0000_0000, 1'b1);

        // R9 and R8 wrap: new position, then a step that crosses 2^16
        hwr(4'd0, 64'h0000_0003_FFFE);
        hwr(4'd2, 64'h0000_FFFF_0003);
        hwr(4'd1, 64'd4);
        chk(px_x == 16'hFFFE && px_y == 16'h0003, "R9", "position write",
            {32'd0, px_y, px_x}, 64'h0003_FFFE);
        row(32'hF000_0000, 1'b0);
        row(32'h5000_0000, 1'b0);

        // Random rows
        for (int n = 0; n < 40; n++) begin
            if (($urandom % 3) == 0) hwr(4'd0, {32'd0, $urandom});
            if (($urandom % 2) == 0) hwr(4'd1, 64'($urandom_range(0, 63)));
            if (($urandom % 4) == 0) hwr(4'd2, {32'd0, $urandom});
            if (($urandom % 3) == 0) hwr(4'd5, {$urandom, $urandom});
            if (($urandom % 3) == 0) hwr(4'd6, 64'($urandom % 64));
            if (($urandom % 5) == 0) hwr(4'd7, {32'd0, $urandom});
            row($urandom, ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule